// File: doc/BRIEF.md
# Memory Controller Configuration Register Slave

This block is the software-visible register file of a DRAM controller. It sits behind a 2 KiB memory-mapped window and serves single-word read and write requests that arrive with a byte offset. The word slot is chosen by five offset bits. Because the other offset bits play no part in the decode, the 32 slots repeat through the whole window.

Two of the slots hold fixed identification values: a system identifier and a silicon revision. Two slots hold writable bytes: the RAM configuration byte and the GPIO direction-enable byte. Each writable byte is kept in bits [31:24] of its word. The RAM configuration byte is also driven out continuously for a bank-mapping block. A one-cycle flag marks each write that actually changes it. Writes to the GPIO output slot are not stored. Each one is passed on as a one-cycle strobe that carries the written top byte. Read data comes back one cycle after the request and is marked by a valid strobe.

Top module: `mcr_cfg_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ram_cfg`, the stored GPIO enable byte, `rd_valid`, `ram_cfg_changed` and `gpio_out_valid` all become zero.
- R2: The slot index is `req_offset[6:2]`. Offset bits [10:7] and [1:0] have no effect on which slot is accessed.
- R3: Slot 0 reads 0x40010000, and writes to slot 0 change nothing that can be observed.
- R4: Slot 1 reads the revision word 0x00000001.
- R5: Slot 4 (GPIO output) and slot 5 (GPIO input) always read 0x00000000.
- R6: A write to slot 3 stores `req_wdata[31:24]` as the GPIO enable byte. A read of slot 3 returns that byte in bits [31:24] with bits [23:0] zero.
- R7: A write to slot 2 stores `req_wdata[31:24]` on `ram_cfg` from the cycle after the write. A read of slot 2 returns the byte in bits [31:24] with bits [23:0] zero.
- R8: `ram_cfg_changed` is high for exactly the one cycle after a slot-2 write whose byte differs from the stored byte. A write of the same value gives no pulse.
- R9: A write to slot 4 raises `gpio_out_valid` for one cycle in the following cycle, with `gpio_out_byte` equal to `req_wdata[31:24]`. No other request raises it.
- R10: Slots 6 to 31 read zero, and writes to them leave every register unchanged.
- R11: `rd_valid` is high in exactly the cycle after each read request and low otherwise. `rd_data` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 11 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid strobe |
| rd_data | output | 32 | Read data |
| ram_cfg | output | 8 | Current RAM configuration byte |
| ram_cfg_changed | output | 1 | One-cycle flag: configuration byte changed |
| gpio_out_valid | output | 1 | One-cycle strobe for a GPIO output write |
| gpio_out_byte | output | 8 | Byte written to the GPIO output slot |

## Verification
A wrong stored byte shows up in two places. For the configuration byte it appears on `ram_cfg` one cycle after the faulty write. For either stored byte it appears in the top byte of the next read of that slot, one cycle after the read is issued. A decode fault shows up at once in several ways: the wrong constant on a read, a write that lands in a neighbouring slot, or a missing or extra strobe in the cycle after the request. Aliased offsets and same-value writes are exercised so that faults in the address slice and in the change comparison become visible.

// File: rtl/mcr_pkg.sv
// Package: shared slot numbers and fixed words for the configuration register slave.
// Assumes 32-bit data words and a five-bit slot index.
package mcr_pkg;
    localparam int IDX_W   = 5;
    localparam int IDX_LO  = 2;
    localparam int SLOTS   = 1 << IDX_W;
    localparam int BYTE_W  = 8;

    localparam logic [IDX_W-1:0] SLOT_ID     = 5'd0;
    localparam logic [IDX_W-1:0] SLOT_REV    = 5'd1;
    localparam logic [IDX_W-1:0] SLOT_CFG    = 5'd2;
    localparam logic [IDX_W-1:0] SLOT_GPEN   = 5'd3;
    localparam logic [IDX_W-1:0] SLOT_GPOUT  = 5'd4;
    localparam logic [IDX_W-1:0] SLOT_GPIN   = 5'd5;

    localparam logic [31:0] ID_WORD  = 32'h4001_0000;
    localparam logic [31:0] REV_WORD = 32'h0000_0001;

    typedef logic [IDX_W-1:0] slot_t;
endpackage

// File: rtl/mcr_decode.sv
// Module: mcr_decode
// Turns a byte offset into a slot index and a one-hot write-select vector.
// Assumes only offset bits [IDX_LO+IDX_W-1:IDX_LO] take part in the decode.
module mcr_decode
    import mcr_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic              wr_en,
    output slot_t             idx,
    output logic [SLOTS-1:0]  wr_hit
);
    localparam int IDX_HI = IDX_LO + IDX_W - 1;

    logic unused_offset_bits;

    // Slice the slot index out of the offset
    assign idx = offset[IDX_HI:IDX_LO];
    // Fold the bits that take no part in the decode
    assign unused_offset_bits = ^{offset[ADDR_W-1:IDX_HI+1], offset[IDX_LO-1:0]};

    // One write strobe per slot
    for (genvar s = 0; s < SLOTS; s++) begin : g_hit
        assign wr_hit[s] = wr_en && (idx == slot_t'(s));
    end
endmodule

// File: rtl/mcr_regs.sv
// Module: mcr_regs
// Holds the RAM configuration and GPIO enable bytes and generates the change flag
// and the GPIO output strobe. Assumes at most one write per cycle.
module mcr_regs
    import mcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_cfg,
    input  logic              sel_gpen,
    input  logic              sel_gpout,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [BYTE_W-1:0] cfg_q,
    output logic [BYTE_W-1:0] gpen_q,
    output logic              cfg_chg,
    output logic              gout_vld,
    output logic [BYTE_W-1:0] gout_byte
);
    // Configuration byte and its change flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            cfg_chg <= 1'b0;
        end else begin
            cfg_chg <= sel_cfg && (wbyte != cfg_q);
            if (sel_cfg) cfg_q <= wbyte;
        end
    end

    // GPIO direction enable byte
    always_ff @(posedge clk) begin
        if (!rst_n)        gpen_q <= '0;
        else if (sel_gpen) gpen_q <= wbyte;
    end

    // GPIO output strobe with its byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gout_vld  <= 1'b0;
            gout_byte <= '0;
        end else begin
            gout_vld <= sel_gpout;
            if (sel_gpout) gout_byte <= wbyte;
        end
    end
endmodule

// File: rtl/mcr_rdmux.sv
// Module: mcr_rdmux
// Selects the read word for the addressed slot and registers it with a valid strobe.
// Assumes the data word is 32 bits with stored bytes in the top byte lane.
module mcr_rdmux
    import mcr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  slot_t             idx,
    input  logic [BYTE_W-1:0] cfg_q,
    input  logic [BYTE_W-1:0] gpen_q,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAD_W = DATA_W - BYTE_W;

    logic [DATA_W-1:0] word_sel;

    // Choose the word for the current slot
    always_comb begin
        case (idx)
            SLOT_ID:   word_sel = DATA_W'(ID_WORD);
            SLOT_REV:  word_sel = DATA_W'(REV_WORD);
            SLOT_CFG:  word_sel = {cfg_q, {PAD_W{1'b0}}};
            SLOT_GPEN: word_sel = {gpen_q, {PAD_W{1'b0}}};
            default:   word_sel = '0;
        endcase
    end

    // Register the read word and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= word_sel;
        end
    end
endmodule

// File: rtl/mcr_cfg_regs.sv
// Module: mcr_cfg_regs (top)
// Memory controller configuration register slave: decodes a byte offset into one
// of 32 word slots, stores top-byte fields and returns read data one cycle later.
// Assumes one request per cycle and full-word accesses.
module mcr_cfg_regs
    import mcr_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [BYTE_W-1:0] ram_cfg,
    output logic              ram_cfg_changed,
    output logic              gpio_out_valid,
    output logic [BYTE_W-1:0] gpio_out_byte
);
    slot_t             idx;
    logic [SLOTS-1:0]  wr_hit;
    logic [BYTE_W-1:0] wbyte;
    logic [BYTE_W-1:0] gpen_q;
    logic              wr_en;
    logic              rd_en;
    logic              unused_wdata_low;

    // Split the request into read and write enables
    assign wr_en = req_valid && req_write;
    assign rd_en = req_valid && !req_write;
    // Only the top byte lane carries stored data
    assign wbyte = req_wdata[DATA_W-1 -: BYTE_W];
    assign unused_wdata_low = ^req_wdata[DATA_W-BYTE_W-1:0];

    mcr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .offset (req_offset),
        .wr_en  (wr_en),
        .idx    (idx),
        .wr_hit (wr_hit)
    );

    mcr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_cfg   (wr_hit[SLOT_CFG]),
        .sel_gpen  (wr_hit[SLOT_GPEN]),
        .sel_gpout (wr_hit[SLOT_GPOUT]),
        .wbyte     (wbyte),
        .cfg_q     (ram_cfg),
        .gpen_q    (gpen_q),
        .cfg_chg   (ram_cfg_changed),
        .gout_vld  (gpio_out_valid),
        .gout_byte (gpio_out_byte)
    );

    mcr_rdmux #(.DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .idx      (idx),
        .cfg_q    (ram_cfg),
        .gpen_q   (gpen_q),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/mcr_cfg_regs_chk.sv
// Module: mcr_cfg_regs_chk
// Port-level temporal checks for mcr_cfg_regs, attached by bind.
module mcr_cfg_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [10:0] req_offset,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic [7:0]  ram_cfg,
    input logic        ram_cfg_changed,
    input logic        gpio_out_valid
);
    // R11
    rd_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    // R11
    no_stray_rdvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable(ram_cfg));

    // R8
    cfg_flag_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cfg_changed |-> (ram_cfg != $past(ram_cfg)));

    // R9
    gpio_strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_out_valid |-> $past(req_valid && req_write && (req_offset[6:2] == 5'd4)));

    // R3
    id_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (req_offset[6:2] == 5'd0)) |=> (rd_data == 32'h4001_0000));
endmodule

bind mcr_cfg_regs mcr_cfg_regs_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_write       (req_write),
    .req_offset      (req_offset),
    .rd_valid        (rd_valid),
    .rd_data         (rd_data),
    .ram_cfg         (ram_cfg),
    .ram_cfg_changed (ram_cfg_changed),
    .gpio_out_valid  (gpio_out_valid)
);

// File: tb/tb_mcr_cfg_regs.sv
module tb_mcr_cfg_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [10:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [7:0]  ram_cfg;
    logic        ram_cfg_changed;
    logic        gpio_out_valid;
    logic [7:0]  gpio_out_byte;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mcr_cfg_regs dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .ram_cfg(ram_cfg), .ram_cfg_changed(ram_cfg_changed),
        .gpio_out_valid(gpio_out_valid), .gpio_out_byte(gpio_out_byte)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write one word; at return the cycle after the write is being sampled
    task automatic wr(input logic [10:0] off, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_offset = off; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [10:0] off, output logic [31:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_offset = off;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data; v = rd_valid;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic v;
        chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        chk("R1 ram_cfg", {24'd0, ram_cfg}, 32'd0);
        chk("R1 cfg_changed", {31'd0, ram_cfg_changed}, 32'd0);
        chk("R1 gpio_out_valid", {31'd0, gpio_out_valid}, 32'd0);
        rd(11'h00C, d, v);
        chk("R1 gpio enable after reset", d, 32'd0);
    endtask

    task automatic t_ident();
        logic [31:0] d; logic v;
        rd(11'h000, d, v);
        chk("R3 id read", d, 32'h4001_0000);
        chk("R11 rd_valid on read", {31'd0, v}, 32'd1);
        @(negedge clk);
        chk("R11 rd_valid drops", {31'd0, rd_valid}, 32'd0);
        wr(11'h000, 32'hFFFF_FFFF);
        chk("R11 no rd_valid on write", {31'd0, rd_valid}, 32'd0);
        rd(11'h000, d, v);
        chk("R3 id after write", d, 32'h4001_0000);
        rd(11'h004, d, v);
        chk("R4 revision", d, 32'h0000_0001);
    endtask

    task automatic t_gpio();
        logic [31:0] d; logic v;
        wr(11'h00C, 32'hA5_123456);
        rd(11'h00C, d, v);
        chk("R6 gpio enable readback", d, 32'hA500_0000);
        wr(11'h010, 32'h3C_FFFFFF);
        @(negedge clk);
        chk("R9 strobe is one cycle", {31'd0, gpio_out_valid}, 32'd0);
        rd(11'h010, d, v);
        chk("R5 gpio out read", d, 32'd0);
        rd(11'h014, d, v);
        chk("R5 gpio in read", d, 32'd0);
    endtask

    task automatic t_gpio_strobe();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_offset = 11'h010; req_wdata = 32'h5A00_0000;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R9 strobe", {31'd0, gpio_out_valid}, 32'd1);
        chk("R9 byte", {24'd0, gpio_out_byte}, 32'h5A);
        @(negedge clk);
        chk("R9 strobe low", {31'd0, gpio_out_valid}, 32'd0);
    endtask

    task automatic t_cfg();
        logic [31:0] d; logic v;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_offset = 11'h008; req_wdata = 32'h7E00_00FF;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R7 ram_cfg", {24'd0, ram_cfg}, 32'h7E);
        chk("R8 change pulse", {31'd0, ram_cfg_changed}, 32'd1);
        @(negedge clk);
        chk("R8 pulse one cycle", {31'd0, ram_cfg_changed}, 32'd0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_offset = 11'h008; req_wdata = 32'h7E00_0000;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R8 same value no pulse", {31'd0, ram_cfg_changed}, 32'd0);
        rd(11'h008, d, v);
        chk("R7 cfg readback", d, 32'h7E00_0000);
    endtask

    task automatic t_unknown();
        logic [31:0] d; logic v;
        for (int s = 6; s < 32; s += 5) begin
            wr(11'(s * 4), 32'hFF00_0000);
            rd(11'(s * 4), d, v);
            chk("R10 unknown slot read", d, 32'd0);
        end
        chk("R10 ram_cfg untouched", {24'd0, ram_cfg}, 32'h7E);
        rd(11'h00C, d, v);
        chk("R10 gpio enable untouched", d, 32'hA500_0000);
    endtask

    task automatic t_alias();
        logic [31:0] d; logic v;
        rd(11'h784, d, v);
        chk("R2 high bits alias revision", d, 32'h0000_0001);
        wr(11'h68B, 32'h1900_0000);
        chk("R2 aliased write to cfg", {24'd0, ram_cfg}, 32'h19);
        rd(11'h00E, d, v);
        chk("R2 low bits ignored", d, 32'hA500_0000);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 cfg cleared by reset", {24'd0, ram_cfg}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ident();
        t_gpio();
        t_gpio_strobe();
        t_cfg();
        t_unknown();
        t_alias();
        t_reset_again();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule